// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits behind an ARINC 429 bit receiver. The receiver assembles a 32-bit word and marks its completion with a one-cycle end-of-sequence strobe. On that strobe the filter checks parity over the whole word and replaces bit 32 with an error flag. A word with bad parity is still kept. The filter can then accept or reject the word against a programmable table of labels and against a programmed value for the two source/destination bits. Accepted words go into a 32-entry FIFO. Rejected words leave no trace.

The host loads the label table one entry at a time through a write port. Each entry carries its own valid bit. The host reads each stored word as two 16-bit halves: the low half comes first, and the high half comes second. The FIFO advances only after the high half has been read. The host sees data-ready, half-full and full flags. A sticky overflow flag records any accepted word that was lost because the FIFO was full. The host clears that flag with a write pulse.

ARINC bit n maps to `word_i[n-1]`. The label is `word_i[7:0]`, bits 9 and 10 are `word_i[8]` and `word_i[9]`, and the parity bit is `word_i[31]`.

Top module: `a429_rx_filter`

## Requirements
- R1: When `eos_i` is high on a clock edge and the 32-bit word has odd parity, the word is stored with bit 31 forced to 0 and all other bits unchanged.
- R2: When the word has even parity, it is still stored, with bit 31 forced to 1 and all other bits unchanged.
- R3: An accepted word that arrives while the FIFO holds 32 words, and no pop happens in that cycle, is discarded and sets `overflow_o`. `overflow_o` stays high until a cycle with `ovf_clr_i` high and no new discard; in that case it reads 0 from the next cycle.
- R4: With `lbl_en_i` high, a word is stored only if `word_i[7:0]` equals a table entry whose valid bit is set. A table write at `lbl_addr_i` with `lbl_wr_i` high sets that entry to `lbl_data_i` and sets its valid bit to `lbl_valid_i`.
- R5: With `lbl_en_i` low, the label does not affect storage.
- R6: With `sd_en_i` high, a word is stored only if `word_i[8]` equals `sd_match_i[0]` and `word_i[9]` equals `sd_match_i[1]`. With `sd_en_i` low, these bits are not checked.
- R7: With both filters enabled, a word must pass both filters to be stored. A word that fails either filter is discarded without setting `overflow_o`.
- R8: No word is stored in a cycle where `eos_i` is low.
- R9: `rd_data_o` shows the low 16 bits of the oldest word. After one `rd_i` pulse it shows that word's high 16 bits. The second `rd_i` pulse removes the word. An `rd_i` pulse while the FIFO is empty has no effect.
- R10: `data_ready_o` is high when the FIFO holds at least 1 word, `half_full_o` is high when it holds 16 or more words, and `full_o` is high when it holds 32 words.
- R11: Words leave the FIFO in the order they were stored. A push and a pop in the same cycle leave the count unchanged, including when the FIFO is full.
- R12: After reset, the FIFO is empty, all flags are low, and every label table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_i | input | 32 | Assembled received word |
| eos_i | input | 1 | End-of-sequence strobe, one cycle |
| lbl_en_i | input | 1 | Enable for the label filter |
| sd_en_i | input | 1 | Enable for the bits 9/10 filter |
| sd_match_i | input | 2 | Required values of bit 10 (msb) and bit 9 (lsb) |
| lbl_wr_i | input | 1 | Label table write strobe |
| lbl_addr_i | input | 4 | Label table entry index |
| lbl_data_i | input | 8 | Label value to write |
| lbl_valid_i | input | 1 | Valid bit to write with the entry |
| rd_i | input | 1 | Host read strobe, one half per pulse |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| rd_data_o | output | 16 | Current half of the oldest word |
| data_ready_o | output | 1 | FIFO not empty |
| half_full_o | output | 1 | FIFO holds at least 16 words |
| full_o | output | 1 | FIFO holds 32 words |
| overflow_o | output | 1 | Sticky flag for an accepted word lost to a full FIFO |

## Verification
The hard case is a push and a pop in the same cycle. A new word's strobe can land on the same edge as the host's second-half read that releases the oldest word. The bench fills the FIFO to 32 words, reads the low half, and then raises `eos_i` on the same edge as the second `rd_i`. The result is correct if `full_o` stays high, `overflow_o` stays low, and the later drain returns the 31 remaining words and then the new one, in order and with correct parity flags.

// File: rtl/a429_rx_filter.sv
module a429_rx_filter #(
  parameter int DEPTH = 32,
  parameter int LBL_N = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              word_i,
  input  logic                     eos_i,
  input  logic                     lbl_en_i,
  input  logic                     sd_en_i,
  input  logic [1:0]               sd_match_i,
  input  logic                     lbl_wr_i,
  input  logic [$clog2(LBL_N)-1:0] lbl_addr_i,
  input  logic [7:0]               lbl_data_i,
  input  logic                     lbl_valid_i,
  input  logic                     rd_i,
  input  logic                     ovf_clr_i,
  output logic [15:0]              rd_data_o,
  output logic                     data_ready_o,
  output logic                     half_full_o,
  output logic                     full_o,
  output logic                     overflow_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [7:0]    lbl_tab [LBL_N];
  logic [LBL_N-1:0] lbl_vld;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic          upper_q;
  logic          lbl_hit, pass, pop, push, lost;

  always_comb begin
    lbl_hit = 1'b0;
    for (int i = 0; i < LBL_N; i++)
      if (lbl_vld[i] && lbl_tab[i] == word_i[7:0]) lbl_hit = 1'b1;
  end

  assign pass = (!lbl_en_i || lbl_hit) && (!sd_en_i || word_i[9:8] == sd_match_i);
  assign pop  = rd_i && upper_q && count_q != '0;
  assign push = eos_i && pass && (count_q != FULL_C || pop);
  assign lost = eos_i && pass && count_q == FULL_C && !pop;

  assign data_ready_o = count_q != '0;
  assign half_full_o  = count_q >= HALF_C;
  assign full_o       = count_q == FULL_C;
  assign rd_data_o    = upper_q ? mem[rd_ptr][31:16] : mem[rd_ptr][15:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lbl_vld <= '0;
    else if (lbl_wr_i) lbl_vld[lbl_addr_i] <= lbl_valid_i;

  always_ff @(posedge clk)
    if (lbl_wr_i) lbl_tab[lbl_addr_i] <= lbl_data_i;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {~^word_i, word_i[30:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count_q    <= '0;
      upper_q    <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
      if (push && !pop) count_q <= count_q + 1'b1;
      else if (pop && !push) count_q <= count_q - 1'b1;
      if (rd_i && count_q != '0) upper_q <= ~upper_q;
      if (lost) overflow_o <= 1'b1;
      else if (ovf_clr_i) overflow_o <= 1'b0;
    end
endmodule

// File: rtl/a429_rx_filter_chk.sv
module a429_rx_filter_chk #(
  parameter int DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       eos_i,
  input logic                       rd_i,
  input logic                       ovf_clr_i,
  input logic                       data_ready_o,
  input logic                       half_full_o,
  input logic                       full_o,
  input logic                       overflow_o,
  input logic [$clog2(DEPTH+1)-1:0] count_q
);
  localparam int CW = $clog2(DEPTH + 1);

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  p_hf_dr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    half_full_o |-> data_ready_o);
  p_full_hf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> half_full_o);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o && !ovf_clr_i |=> overflow_o);
  p_no_push_without_eos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready_o && !eos_i |=> !data_ready_o);
  p_ready_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o && !rd_i |=> data_ready_o);
  p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)
             || (count_q + 1'b1 == $past(count_q)));
endmodule

bind a429_rx_filter a429_rx_filter_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .eos_i(eos_i), .rd_i(rd_i), .ovf_clr_i(ovf_clr_i),
  .data_ready_o(data_ready_o), .half_full_o(half_full_o), .full_o(full_o),
  .overflow_o(overflow_o), .count_q(count_q));

// File: tb/a429_rx_filter_tb_top.sv
module a429_rx_filter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] word_i = '0;
  logic eos_i = 0, lbl_en_i = 0, sd_en_i = 0, lbl_wr_i = 0, lbl_valid_i = 0, rd_i = 0, ovf_clr_i = 0;
  logic [1:0] sd_match_i = '0;
  logic [3:0] lbl_addr_i = '0;
  logic [7:0] lbl_data_i = '0;
  logic [15:0] rd_data_o;
  logic data_ready_o, half_full_o, full_o, overflow_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  a429_rx_filter dut_i (.*);

  // vector table: word, control {lbl_en, sd_en, sd_match[1:0]}, store expected
  localparam int NV = 16;
  localparam logic [31:0] VW [NV] = '{
    32'h0000_0001, 32'h8000_0003, 32'h0000_0003, 32'h8000_0000,
    32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_000A, 32'h5A5A_00C3,
    32'h0000_0055, 32'h0000_0077, 32'h0000_0077, 32'h0000_0277,
    32'h0000_0277, 32'h0000_030A, 32'h0000_030A, 32'h0000_0377};
  localparam logic [3:0] VC [NV] = '{
    4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 4'b1000,
    4'b1000, 4'b1000, 4'b0000, 4'b0110, 4'b0101, 4'b1111, 4'b1100, 4'b1111};
  localparam bit [0:NV-1] VS = 16'b1111_1111_0011_0100;

  function automatic logic [31:0] exp_word(input logic [31:0] w);
    return {~^w, w[30:0]};
  endfunction

  function automatic string vtag(input int i);
    case (i)
      0, 1, 3, 4: return "R1";
      2, 5:       return "R2";
      6, 7, 8, 9: return "R4";
      10:         return "R5";
      11, 12:     return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    word_i = w; eos_i = 1'b1;
    @(negedge clk); eos_i = 1'b0;
  endtask

  task automatic rd_half(output logic [15:0] v);
    v = rd_data_o; rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic lbl_write(input int a, input logic [7:0] d, input logic v);
    lbl_addr_i = 4'(a); lbl_data_i = d; lbl_valid_i = v; lbl_wr_i = 1'b1;
    @(negedge clk); lbl_wr_i = 1'b0;
  endtask

  task automatic read_word(input string tag, input logic [31:0] exp);
    logic [15:0] lo, hi;
    rd_half(lo);
    rd_half(hi);
    chk(tag, {hi, lo}, exp);
  endtask

  function automatic logic [31:0] fw(input int i);
    return {16'hA000 + 16'(i), 16'(i * 3)};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lo;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 flags", {28'd0, data_ready_o, half_full_o, full_o, overflow_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    lbl_en_i = 1'b1;
    push(32'h0000_0100);
    chk("R12 label entries invalid", {31'd0, data_ready_o}, 32'd0);
    lbl_en_i = 1'b0;
    // R8 no strobe
    word_i = 32'h1234_5671;
    repeat (3) @(negedge clk);
    chk("R8 no eos", {31'd0, data_ready_o}, 32'd0);
    // R9 read on empty ignored
    rd_half(lo);
    push(32'hCAFE_0001);
    rd_half(lo);
    chk("R9 low half first after empty read", {16'd0, lo}, {16'd0, 16'h0001});
    rd_half(lo);
    chk("R9 high half second", {16'd0, lo}, {16'd0, exp_word(32'hCAFE_0001) >> 16});
    chk("R9 pop after second read", {31'd0, data_ready_o}, 32'd0);

    lbl_write(0, 8'h0A, 1'b1);
    lbl_write(5, 8'hC3, 1'b1);
    lbl_write(7, 8'h55, 1'b0);

    for (int i = 0; i < NV; i++) begin
      lbl_en_i = VC[i][3]; sd_en_i = VC[i][2]; sd_match_i = VC[i][1:0];
      push(VW[i]);
      chk({vtag(i), " store decision"}, {31'd0, data_ready_o}, {31'd0, VS[i]});
      if (VS[i]) read_word({vtag(i), " stored word"}, exp_word(VW[i]));
      chk({vtag(i), " no overflow on filter drop"}, {31'd0, overflow_o}, 32'd0);
    end
    lbl_en_i = 1'b0; sd_en_i = 1'b0;

    // R10 fill levels, R3 overflow, R11 order and simultaneous push/pop
    for (int i = 0; i < 15; i++) push(fw(i));
    chk("R10 15 words", {29'd0, data_ready_o, half_full_o, full_o}, 32'b100);
    push(fw(15));
    chk("R10 16 words", {29'd0, data_ready_o, half_full_o, full_o}, 32'b110);
    for (int i = 16; i < 31; i++) push(fw(i));
    chk("R10 31 words", {29'd0, data_ready_o, half_full_o, full_o}, 32'b110);
    push(fw(31));
    chk("R10 32 words", {29'd0, data_ready_o, half_full_o, full_o}, 32'b111);
    push(32'hDEAD_BEEF);
    chk("R3 overflow set", {31'd0, overflow_o}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R3 overflow sticky", {31'd0, overflow_o}, 32'd1);
    ovf_clr_i = 1'b1; @(negedge clk); ovf_clr_i = 1'b0;
    chk("R3 overflow cleared", {31'd0, overflow_o}, 32'd0);
    rd_half(lo);
    chk("R11 oldest low half", {16'd0, lo}, {16'd0, exp_word(fw(0)) & 32'hFFFF});
    word_i = fw(32); eos_i = 1'b1; rd_i = 1'b1;
    @(negedge clk); eos_i = 1'b0; rd_i = 1'b0;
    chk("R11 full after push+pop", {30'd0, full_o, overflow_o}, 32'b10);
    for (int i = 1; i <= 32; i++) read_word($sformatf("R11 order word %0d", i), exp_word(fw(i)));
    chk("R11 drained", {31'd0, data_ready_o}, 32'd0);
    finish_run();
  end
endmodule